// File: doc/BRIEF.md
# Channel Status Double Buffer

This block keeps one complete 192-bit channel status block for each of the two audio subchannels, A and B, in two cascaded stores. The host store is a set of registers that a host reads and writes over a simple byte-wide bus. The transmit store is the only source of the bits that a serial audio transmitter sends. The transmitter draws one channel status bit per subchannel in each frame.

At every block boundary of the output timebase, a one-cycle `block_start_i` strobe copies the whole host store into the transmit store in one cycle and restarts the frame index at 0. The host can hold an inhibit bit to block the copy while it rewrites the host store. A sticky flag, which can be masked onto an interrupt line, tells the host that a copy has taken place and that a safe window to update the host store has begun.

When a subchannel's transmitted block is marked professional, the block computes the CRCC as the bits go out. It sends the CRCC in place of the last byte.

Top module: `chstat_dbuf`

## Requirements
- R1: After reset, every register address reads 0x00. `cs_a_o`, `cs_b_o` and `irq_o` are 0, and the transmit store is all zero.
- R2: Byte n (0..23) of subchannel A sits at bus address 0x20+n, and byte n of subchannel B sits at 0x38+n. A write takes effect at the clock edge. The read data is combinational from the address.
- R3: Any address other than 0x10, 0x11 and 0x20..0x4F reads 0x00, and a write to it changes no register.
- R4: On a `block_start_i` cycle with inhibit clear, the whole host store is copied to the transmit store and the frame index becomes 0. Each `frame_adv_i` cycle without `block_start_i` advances the index. After 191 the index wraps to 0. Frame k carries bit 7-(k mod 8) of byte k/8, so the most significant bit goes out first.
- R5: A host write does not change the transmitted bits until a later transfer.
- R6: Control register 0x10 bit 0 is the inhibit bit. While it is 1, `block_start_i` copies nothing and sets no flag. It only restarts the index, and the old block keeps repeating. The dropped transfer is not carried out later.
- R7: Register 0x11 bit 0 is a sticky transfer flag. It is set by every transfer and cleared by writing 1 to it. If a set and a clear happen in the same cycle, the set wins. Control bit 1 enables the interrupt, and `irq_o` equals flag AND enable. Register 0x10 reads back bits 1:0.
- R8: If bit 7 of byte 0 of a subchannel's transmitted block is 1, frames 184..191 of that subchannel carry a CRCC in place of byte 23, most significant bit first. The CRCC uses x^8+x^4+x^3+x^2+1, is initialised to 0xFF, and covers bits 0..183 in transmission order. Whatever the host wrote to byte 23 is not sent.
- R9: If that flag bit is 0, byte 23 is sent exactly as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| block_start_i | input | 1 | Output block boundary strobe, one cycle |
| frame_adv_i | input | 1 | Advance to next frame |
| cs_a_o | output | 1 | Channel status bit, subchannel A |
| cs_b_o | output | 1 | Channel status bit, subchannel B |
| irq_o | output | 1 | Transfer interrupt |

## Verification
The hardest case to reach is a boundary strobe that is dropped: the transfer must be lost for good, and nothing may show it except the repeated old block. The stimulus first rewrites the host store and raises inhibit, then strobes a boundary. It streams a complete block, clears inhibit, and streams a second full block with no strobe. Both blocks must match the earlier image before a final strobe brings in the new one. Professional CRCC insertion is checked the same way. One subchannel is professional and the other consumer, and both have junk written to byte 23.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
  localparam int NCH       = 2;
  localparam int NBYTES    = 24;
  localparam int BLK_BITS  = NBYTES * 8;
  localparam int CRC_BITS  = BLK_BITS - 8;
  localparam int AW        = 8;
  localparam int DW        = 8;
  localparam logic [AW-1:0] CTRL_ADDR = 8'h10;
  localparam logic [AW-1:0] STAT_ADDR = 8'h11;
  localparam logic [AW-1:0] E_BASE    = 8'h20;
  localparam logic [7:0]    CRC_POLY  = 8'h1D;
endpackage

// File: rtl/chstat_host_regs.sv
module chstat_host_regs
  import chstat_pkg::*;
#(
  parameter int NB = NCH * NBYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  input  logic                 bus_we_i,
  output logic [DW-1:0]        bus_rdata_o,
  input  logic                 xfer_i,
  output logic [NB-1:0][7:0]   e_o,
  output logic                 inhibit_o,
  output logic                 irq_en_o,
  output logic                 flag_o
);
  localparam int IW = $clog2(NB);

  logic [NB-1:0][7:0] e_q;
  logic [AW-1:0]      off;
  logic               in_e;
  logic               inh_q, ien_q, flag_q;

  assign off  = bus_addr_i - E_BASE;
  assign in_e = (bus_addr_i >= E_BASE) && (off < AW'(NB));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q    <= '0;
      inh_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (bus_we_i && in_e) e_q[off[IW-1:0]] <= bus_wdata_i;
      if (bus_we_i && bus_addr_i == CTRL_ADDR) begin
        inh_q <= bus_wdata_i[0];
        ien_q <= bus_wdata_i[1];
      end
      // set has priority over write-one-to-clear
      if (xfer_i) flag_q <= 1'b1;
      else if (bus_we_i && bus_addr_i == STAT_ADDR && bus_wdata_i[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (in_e)                          bus_rdata_o = e_q[off[IW-1:0]];
    else if (bus_addr_i == CTRL_ADDR)  bus_rdata_o = {6'd0, ien_q, inh_q};
    else if (bus_addr_i == STAT_ADDR)  bus_rdata_o = {7'd0, flag_q};
  end

  assign e_o       = e_q;
  assign inhibit_o = inh_q;
  assign irq_en_o  = ien_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/chstat_tx_buf.sv
module chstat_tx_buf
  import chstat_pkg::*;
#(
  parameter int NC   = NCH,
  parameter int NBY  = NBYTES,
  parameter int NB   = NC * NBY,
  parameter int IDXW = $clog2(NBY * 8)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 restart_i,
  input  logic                 adv_i,
  input  logic [NB-1:0][7:0]   e_i,
  output logic [IDXW-1:0]      idx_o,
  output logic                 wrap_o,
  output logic [NC-1:0]        raw_o,
  output logic [NC-1:0]        pro_o
);
  localparam int FW = $clog2(NB);
  localparam logic [IDXW-1:0] LAST = IDXW'(NBY * 8 - 1);

  logic [NB-1:0][7:0] f_q;
  logic [IDXW-1:0]    idx_q;

  assign wrap_o = adv_i && !restart_i && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q   <= '0;
      idx_q <= '0;
    end else begin
      if (load_i) f_q <= e_i;
      if (restart_i || wrap_o) idx_q <= '0;
      else if (adv_i)          idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic [FW-1:0] sel;
    assign sel      = FW'(c * NBY) + FW'(idx_q[IDXW-1:3]);
    assign raw_o[c] = f_q[sel][3'd7 - idx_q[2:0]];
    assign pro_o[c] = f_q[c * NBY][7];
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/chstat_crc.sv
module chstat_crc
  import chstat_pkg::*;
#(
  parameter int IDXW = 8,
  parameter int NBIT = CRC_BITS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            adv_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            bit_i,
  output logic [7:0]      crc_o
);
  logic [7:0] crc_q;
  logic       fb;

  assign fb = crc_q[7] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                crc_q <= 8'hFF;
    else if (restart_i)                         crc_q <= 8'hFF;
    else if (adv_i && idx_i < IDXW'(NBIT))
      crc_q <= {crc_q[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/chstat_dbuf.sv
module chstat_dbuf
  import chstat_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic          bus_we_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          block_start_i,
  input  logic          frame_adv_i,
  output logic          cs_a_o,
  output logic          cs_b_o,
  output logic          irq_o
);
  localparam int NB   = NCH * NBYTES;
  localparam int IDXW = $clog2(BLK_BITS);

  logic [NB-1:0][7:0] e_img;
  logic               inhibit, irq_en, xfer_flag, xfer, wrap;
  logic [IDXW-1:0]    tx_idx;
  logic [NCH-1:0]     raw, pro, cs;

  assign xfer = block_start_i && !inhibit;

  chstat_host_regs #(.NB(NB)) u_host (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wdata_i, .bus_we_i, .bus_rdata_o,
    .xfer_i(xfer), .e_o(e_img), .inhibit_o(inhibit), .irq_en_o(irq_en),
    .flag_o(xfer_flag)
  );

  chstat_tx_buf #(.NC(NCH), .NBY(NBYTES), .NB(NB), .IDXW(IDXW)) u_tx (
    .clk_i, .rst_ni, .load_i(xfer), .restart_i(block_start_i),
    .adv_i(frame_adv_i), .e_i(e_img), .idx_o(tx_idx), .wrap_o(wrap),
    .raw_o(raw), .pro_o(pro)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_crc
    logic [7:0] crc;
    chstat_crc #(.IDXW(IDXW), .NBIT(CRC_BITS)) u_crc (
      .clk_i, .rst_ni, .restart_i(block_start_i || wrap),
      .adv_i(frame_adv_i), .idx_i(tx_idx), .bit_i(raw[c]), .crc_o(crc)
    );
    assign cs[c] = (pro[c] && tx_idx >= IDXW'(CRC_BITS)) ? crc[3'd7 - tx_idx[2:0]] : raw[c];
  end

  assign cs_a_o = cs[0];
  assign cs_b_o = cs[1];
  assign irq_o  = xfer_flag && irq_en;
endmodule

// File: rtl/chstat_dbuf_chk.sv
module chstat_dbuf_chk
  import chstat_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          block_start_i,
  input logic          frame_adv_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic          irq_o,
  input logic          inhibit,
  input logic          irq_en,
  input logic          xfer_flag,
  input logic [7:0]    tx_idx
);
  // R4
  idx_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_start_i |=> tx_idx == 8'd0);
  // R4
  idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_adv_i && !block_start_i && tx_idx == 8'd191) |=> tx_idx == 8'd0);
  // R6
  inhibit_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_start_i && inhibit && !xfer_flag) |=> !xfer_flag);
  // R7
  flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_flag) |-> $past(block_start_i && !inhibit));
  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en && xfer_flag));
  // R3
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != CTRL_ADDR && bus_addr_i != STAT_ADDR &&
     (bus_addr_i < E_BASE || bus_addr_i > 8'h4F)) |-> bus_rdata_o == 8'h00);
endmodule

bind chstat_dbuf chstat_dbuf_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .block_start_i(block_start_i),
  .frame_adv_i(frame_adv_i), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .irq_o(irq_o), .inhibit(inhibit), .irq_en(irq_en), .xfer_flag(xfer_flag),
  .tx_idx(tx_idx)
);

// File: tb/chstat_dbuf_bench.sv
module chstat_dbuf_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic       bus_we_i = 1'b0;
  logic [7:0] bus_rdata_o;
  logic       block_start_i = 1'b0;
  logic       frame_adv_i = 1'b0;
  logic       cs_a_o, cs_b_o, irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] e_model [48];
  logic [7:0] f_model [48];

  always #10 clk_i = ~clk_i;

  chstat_dbuf u_chstat_dbuf (.*);

  // {we, addr, wdata, expected read}
  localparam logic [24:0] VEC [15] = '{
    {1'b1, 8'h20, 8'h3C, 8'h00}, {1'b1, 8'h37, 8'hA5, 8'h00},
    {1'b1, 8'h38, 8'h11, 8'h00}, {1'b1, 8'h4F, 8'h7E, 8'h00},
    {1'b1, 8'h50, 8'hFF, 8'h00}, {1'b1, 8'h1F, 8'hEE, 8'h00},
    {1'b0, 8'h20, 8'h00, 8'h3C}, {1'b0, 8'h37, 8'h00, 8'hA5},
    {1'b0, 8'h38, 8'h00, 8'h11}, {1'b0, 8'h4F, 8'h00, 8'h7E},
    {1'b0, 8'h50, 8'h00, 8'h00}, {1'b0, 8'h1F, 8'h00, 8'h00},
    {1'b1, 8'h10, 8'hFE, 8'h00}, {1'b0, 8'h10, 8'h00, 8'h02},
    {1'b0, 8'h11, 8'h00, 8'h00}
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bw(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
    if (a >= 8'h20 && a <= 8'h4F) e_model[a - 8'h20] = d;
  endtask

  task automatic br(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk_i);
    bus_addr_i = a;
    #2 check(tag, bus_rdata_o, exp);
  endtask

  function automatic logic exp_bit(int ch, int k);
    logic [7:0] c;
    logic fb;
    if (f_model[ch*24][7] && k >= 184) begin
      c = 8'hFF;
      for (int j = 0; j < 184; j++) begin
        fb = c[7] ^ f_model[ch*24 + j/8][7 - j%8];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
      end
      return c[7 - (k - 184)];
    end
    return f_model[ch*24 + k/8][7 - k%8];
  endfunction

  // streams one block; start=1 pulses block_start first; xfer tells the model whether it copies
  task automatic run_blk(string tag, bit start, bit xfer);
    int bad = 0;
    logic [1:0] act = '0, exp = '0;
    if (start) begin
      @(negedge clk_i); block_start_i = 1'b1;
      @(negedge clk_i); block_start_i = 1'b0;
      if (xfer) f_model = e_model;
    end else @(negedge clk_i);
    frame_adv_i = 1'b1;
    for (int k = 0; k < 192; k++) begin
      if (k > 0) @(negedge clk_i);
      if ({cs_b_o, cs_a_o} !== {exp_bit(1, k), exp_bit(0, k)} && bad == 0) begin
        act = {cs_b_o, cs_a_o}; exp = {exp_bit(1, k), exp_bit(0, k)};
        $display("frame %0d mismatch in %s", k, tag);
        bad++;
      end
    end
    @(negedge clk_i);
    frame_adv_i = 1'b0;
    check(tag, {6'd0, act}, {6'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 48; i++) begin e_model[i] = '0; f_model[i] = '0; end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    br("R1 read 0x20", 8'h20, 8'h00);
    br("R1 read 0x4F", 8'h4F, 8'h00);
    br("R1 read ctrl", 8'h10, 8'h00);
    check("R1 outputs", {5'd0, cs_a_o, cs_b_o, irq_o}, 8'h00);
    rst_ni = 1'b1;
    run_blk("R1 zero stream", 1'b0, 1'b0);

    // R2 R3 R7 register table
    foreach (VEC[i]) begin
      if (VEC[i][24]) bw(VEC[i][23:16], VEC[i][15:8]);
      else br($sformatf("bus table (R2 R3 R7) entry %0d", i), VEC[i][23:16], VEC[i][7:0]);
    end

    // consumer blocks, byte 23 sent raw: R4 R9
    for (int i = 0; i < 48; i++) bw(8'h20 + 8'(i), 8'((i * 37 + 5) & 8'h7F) | ((i % 24 == 0) ? 8'h00 : 8'(i << 7)));
    bw(8'h37, 8'hC3);
    bw(8'h4F, 8'h96);
    br("R7 flag before transfer", 8'h11, 8'h00);
    run_blk("R4 R9 consumer transfer", 1'b1, 1'b1);
    br("R7 flag set", 8'h11, 8'h01);
    check("R7 irq asserted", {7'd0, irq_o}, 8'h01);
    bw(8'h11, 8'h00);
    br("R7 write 0 keeps flag", 8'h11, 8'h01);
    bw(8'h11, 8'h01);
    br("R7 w1c clears", 8'h11, 8'h00);
    check("R7 irq cleared", {7'd0, irq_o}, 8'h00);

    // R5 host writes do not reach the line
    bw(8'h21, 8'h5A);
    bw(8'h3B, 8'hE1);
    run_blk("R5 stale after write, R4 wrap", 1'b0, 1'b0);

    // R6 inhibited boundary, dropped request
    bw(8'h10, 8'h03);
    run_blk("R6 inhibited boundary", 1'b1, 1'b0);
    br("R6 no flag", 8'h11, 8'h00);
    bw(8'h10, 8'h02);
    run_blk("R6 dropped not queued", 1'b0, 1'b0);
    run_blk("R4 transfer after inhibit", 1'b1, 1'b1);
    br("R7 flag after resume", 8'h11, 8'h01);
    bw(8'h11, 8'h01);

    // R8 professional A with crc, consumer B
    bw(8'h20, 8'h85);
    bw(8'h37, 8'hAA);
    bw(8'h38, 8'h04);
    bw(8'h4F, 8'hAA);
    run_blk("R8 pro crc A, R9 raw B", 1'b1, 1'b1);
    bw(8'h38, 8'hC1);
    bw(8'h4F, 8'h00);
    run_blk("R8 pro crc both", 1'b1, 1'b1);
    br("R2 byte 23 readback", 8'h37, 8'hAA);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule